// File: doc/BRIEF.md
# Paging MMU Configuration Register File

This block is the byte-wide register file that configures a paging address translator. The virtual address space is split into four quarters. Each quarter has a page-table base address and an enable flag. The register file also holds a staged page index used to drop one cached translation, a global translation enable, and a read-only 16-bit identification word.

Software reaches it through an 8-bit address, 8-bit data port. Writes are committed on the clock edge. Reads are combinational, and a hit flag marks offsets that answer.

Toward the translation logic, the block presents:
- the four bases and their enable flags;
- the global enable;
- two one-cycle invalidate pulses. One flushes a whole quarter and carries the quarter number. The other drops one page entry and carries the 12-bit page index.

Top module: `mmu_cfg_regs`

## Requirements
- R1: After reset every base is zero, all four quarter enables and the translation enable are 0, both invalidate pulses are low, and the staged page index is zero.
- R2: Offsets 0x00–0x0F form four 4-byte quarter slots (quarter = offset[3:2], byte = offset[1:0]). Byte 0 holds address bits 31..24 of that quarter's base and byte 1 holds bits 23..16. Each reads back what was written.
- R3: Byte 2 of a slot keeps only the upper nibble of the written data as base bits 15..12. It reads back with the low nibble zero.
- R4: Byte 3 of a slot sets that quarter's enable from data bit 0 and reads back as 0x00 or 0x01.
- R5: A write to byte 3 of a slot raises `inv_q_pulse` for exactly the one cycle after the write, with `inv_q_idx` equal to the quarter number.
- R6: A write to 0x11 loads page-index bits 11..4 from the data byte. A write to 0x12 loads bits 3..0 from data bits 7..4. A write to 0x10 changes nothing.
- R7: A write to 0x13 raises `inv_pg_pulse` for exactly the one cycle after the write, with `inv_pg_idx` equal to the staged page index.
- R8: A write to 0x15 sets `xlat_en` from data bit 0. No other write changes it.
- R9: A read of 0xFE returns the upper byte of parameter `CARD_ID`, and a read of 0xFF returns the lower byte. Both assert `rd_hit`.
- R10: A read of any offset outside 0x00–0x0F and 0xFE–0xFF gives `rd_hit`=0 and `rdata`=0. A write to an unused offset changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| rd_hit | output | 1 | Read offset is mapped |
| frame_base | output | 80 | Quarter bases, quarter i at [20*i+19:20*i], address bits 31..12 |
| q_enable | output | 4 | Per-quarter enable |
| xlat_en | output | 1 | Global translation enable |
| inv_q_pulse | output | 1 | Quarter invalidate pulse |
| inv_q_idx | output | 2 | Quarter to invalidate |
| inv_pg_pulse | output | 1 | Single-page invalidate pulse |
| inv_pg_idx | output | 12 | Page index to invalidate |

## Verification
Bases are written with distinct per-quarter byte patterns and read back. A byte-2 value with a nonzero low nibble shows whether masking happens, and distinct slot patterns expose any crossing between quarters or bytes.

The enable byte is written with data values whose bit 0 differs from their other bits. This shows whether only bit 0 counts, and the pulse index shows which quarter was flushed.

The page index is staged with a write to 0x10 placed between the loads. The result is read out through the 0x13 pulse, which separates correct nibble placement from a 0x10 write that leaks into the index. Unused offsets are then written and read to show they leave every output unchanged.

// File: rtl/mmu_cfg_regs.sv
module mmu_cfg_regs #(
  parameter logic [15:0] CARD_ID = 16'h4D31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        rd_hit,
  output logic [79:0] frame_base,
  output logic [3:0]  q_enable,
  output logic        xlat_en,
  output logic        inv_q_pulse,
  output logic [1:0]  inv_q_idx,
  output logic        inv_pg_pulse,
  output logic [11:0] inv_pg_idx
);
  localparam int NQ = 4;
  localparam int BW = 20;

  logic [BW-1:0] base_q [NQ];
  logic [11:0]   pg_stage;

  wire in_slots = (addr[7:4] == 4'h0);
  wire [1:0] q  = addr[3:2];

  for (genvar i = 0; i < NQ; i++) begin : g_out
    assign frame_base[i*BW +: BW] = base_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NQ; i++) base_q[i] <= '0;
      q_enable     <= '0;
      xlat_en      <= 1'b0;
      pg_stage     <= '0;
      inv_q_pulse  <= 1'b0;
      inv_q_idx    <= '0;
      inv_pg_pulse <= 1'b0;
      inv_pg_idx   <= '0;
    end else begin
      inv_q_pulse  <= 1'b0;
      inv_pg_pulse <= 1'b0;
      if (wr_en) begin
        if (in_slots) begin
          case (addr[1:0])
            2'd0: base_q[q][19:12] <= wdata;
            2'd1: base_q[q][11:4]  <= wdata;
            2'd2: base_q[q][3:0]   <= wdata[7:4];
            default: begin
              q_enable[q] <= wdata[0];
              inv_q_pulse <= 1'b1;
              inv_q_idx   <= q;
            end
          endcase
        end else begin
          case (addr)
            8'h11: pg_stage[11:4] <= wdata;
            8'h12: pg_stage[3:0]  <= wdata[7:4];
            8'h13: begin
              inv_pg_pulse <= 1'b1;
              inv_pg_idx   <= pg_stage;
            end
            8'h15: xlat_en <= wdata[0];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata  = '0;
    rd_hit = 1'b0;
    if (rd_en) begin
      if (in_slots) begin
        rd_hit = 1'b1;
        case (addr[1:0])
          2'd0:    rdata = base_q[q][19:12];
          2'd1:    rdata = base_q[q][11:4];
          2'd2:    rdata = {base_q[q][3:0], 4'h0};
          default: rdata = {7'd0, q_enable[q]};
        endcase
      end else if (addr == 8'hFE) begin
        rd_hit = 1'b1;
        rdata  = CARD_ID[15:8];
      end else if (addr == 8'hFF) begin
        rd_hit = 1'b1;
        rdata  = CARD_ID[7:0];
      end
    end
  end

  a_r5_q_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    inv_q_pulse |-> $past(wr_en && addr[7:4] == 4'h0 && addr[1:0] == 2'd3));
  a_r7_pg_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    inv_pg_pulse |-> $past(wr_en && addr == 8'h13));
  a_r8_xlat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 8'h15) |=> $stable(xlat_en));
  a_r4_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr[7:4] == 4'h0 && addr[1:0] == 2'd3) |=> $stable(q_enable));
  a_r10_hit_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> rd_en);
  a_r5_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(inv_q_pulse && inv_pg_pulse));
endmodule

// File: tb/tb_mmu_cfg_regs.sv
`timescale 1ns/1ps
module tb_mmu_cfg_regs;
  localparam logic [15:0] ID = 16'h4D31;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic rd_hit, xlat_en, inv_q_pulse, inv_pg_pulse;
  logic [79:0] frame_base;
  logic [3:0] q_enable;
  logic [1:0] inv_q_idx;
  logic [11:0] inv_pg_idx;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mmu_cfg_regs #(.CARD_ID(ID)) dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d, output logic h);
    @(negedge clk); rd_en = 1; addr = a; #1; d = rdata; h = rd_hit; rd_en = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d; logic h;
    check("R1 base", {12'd0, frame_base[19:0]} | frame_base[79:60], 0);
    check("R1 base all", {31'd0, |frame_base}, 0);
    check("R1 enables", {27'd0, q_enable, xlat_en}, 0);
    check("R1 pulses", {30'd0, inv_q_pulse, inv_pg_pulse}, 0);
    wr(8'h13, 0);
    check("R1 stage zero", {20'd0, inv_pg_idx}, 0);
    rd(8'h07, d, h);
    check("R1 en readback", {23'd0, h, d}, {23'd0, 1'b1, 8'h00});
  endtask

  task automatic t_base;
    logic [7:0] d; logic h;
    for (int i = 0; i < 4; i++) begin
      wr(8'(4*i), 8'(8'h10 + i));
      wr(8'(4*i+1), 8'(8'hA0 + i));
      wr(8'(4*i+2), 8'(8'h5F + 16*i));
    end
    for (int i = 0; i < 4; i++) begin
      rd(8'(4*i), d, h);   check("R2 byte0", {23'd0, h, d}, {23'd0, 1'b1, 8'(8'h10 + i)});
      rd(8'(4*i+1), d, h); check("R2 byte1", {24'd0, d}, {24'd0, 8'(8'hA0 + i)});
      rd(8'(4*i+2), d, h); check("R3 byte2 masked", {24'd0, d}, {24'd0, 8'(8'h50 + 16*i)});
      check("R2 R3 base out", {12'd0, frame_base[i*20 +: 20]},
            {12'd0, 8'(8'h10 + i), 8'(8'hA0 + i), 4'(4'h5 + i)});
    end
  endtask

  task automatic t_enable;
    logic [7:0] d; logic h;
    wr(8'h0B, 8'hFE);
    check("R5 q pulse clear-bit", {29'd0, inv_q_pulse, inv_q_idx}, {29'd0, 1'b1, 2'd2});
    check("R4 enable bit0 only", {28'd0, q_enable}, 0);
    @(negedge clk);
    check("R5 pulse one cycle", {31'd0, inv_q_pulse}, 0);
    wr(8'h0F, 8'h01);
    check("R5 q idx 3", {29'd0, inv_q_pulse, inv_q_idx}, {29'd0, 1'b1, 2'd3});
    wr(8'h03, 8'h81);
    check("R4 enables", {28'd0, q_enable}, 32'h9);
    rd(8'h0F, d, h); check("R4 readback 1", {24'd0, d}, 1);
    rd(8'h0B, d, h); check("R4 readback 0", {24'd0, d}, 0);
    check("R8 untouched", {31'd0, xlat_en}, 0);
  endtask

  task automatic t_page;
    wr(8'h11, 8'hC3);
    wr(8'h10, 8'hFF);
    wr(8'h12, 8'h9A);
    wr(8'h13, 8'h00);
    check("R7 R6 pg pulse", {19'd0, inv_pg_pulse, inv_pg_idx}, {19'd0, 1'b1, 12'hC39});
    check("R7 no q pulse", {31'd0, inv_q_pulse}, 0);
    @(negedge clk);
    check("R7 pulse one cycle", {31'd0, inv_pg_pulse}, 0);
    wr(8'h10, 8'h00);
    wr(8'h13, 8'h00);
    check("R6 0x10 ignored", {20'd0, inv_pg_idx}, 32'hC39);
  endtask

  task automatic t_global;
    wr(8'h15, 8'h01); check("R8 set", {31'd0, xlat_en}, 1);
    wr(8'h14, 8'h00); check("R8 other offset", {31'd0, xlat_en}, 1);
    wr(8'h15, 8'hFE); check("R8 bit0 clear", {31'd0, xlat_en}, 0);
  endtask

  task automatic t_id_unmapped;
    logic [7:0] d; logic h;
    logic [79:0] fb;
    rd(8'hFE, d, h); check("R9 id hi", {23'd0, h, d}, {23'd0, 1'b1, ID[15:8]});
    rd(8'hFF, d, h); check("R9 id lo", {23'd0, h, d}, {23'd0, 1'b1, ID[7:0]});
    rd(8'h10, d, h); check("R10 rd 0x10", {23'd0, h, d}, 0);
    rd(8'h15, d, h); check("R10 rd 0x15", {23'd0, h, d}, 0);
    rd(8'hFD, d, h); check("R10 rd 0xFD", {23'd0, h, d}, 0);
    fb = frame_base;
    wr(8'h20, 8'hFF); wr(8'hFE, 8'h00); wr(8'h16, 8'hFF);
    check("R10 wr base", {31'd0, fb == frame_base}, 1);
    check("R10 wr flags", {26'd0, q_enable, xlat_en, inv_q_pulse | inv_pg_pulse}, {26'd0, 4'h9, 2'b00});
    rd(8'hFE, d, h); check("R10 id kept", {24'd0, d}, {24'd0, ID[15:8]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_base; t_enable; t_page; t_global; t_id_unmapped;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule